// File: doc/BRIEF.md
# SMBus Byte-Access Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers and exposes them over SMBus-style single-byte write and single-byte read transactions. The clock and data lines are first passed through a two-stage synchronizer clocked by the system clock. All bus events are derived from these synchronized samples: SCL edges, start conditions, repeated starts and stop conditions.

After a start, the slave compares a fixed 7-bit address. It then takes a command byte. The top bit of the command must be set, which marks a single-byte access. The low seven bits select the register. A write continues with one data byte. A read turns the bus around with a repeated start and a second address phase with the read bit set, and the slave then shifts out one byte. The register contents are driven in parallel to the surrounding logic. Register 0 is also split into a 3-bit spread-select field and a 5-bit frequency-select field. The slave never drives SDA high. It only pulls the line low through `sda_oe`.

The controller walks through these named states:
- IDLE
- ADDR, with the transition to ADDR_ACK on a match or back to IDLE on a mismatch
- ADDR_ACK, which goes to CMD for a write bit or to RDATA for a read bit
- CMD, which goes to CMD_ACK for a valid command or to IDLE otherwise
- CMD_ACK, which goes to WDATA
- WDATA, which goes to WDATA_ACK
- WDATA_ACK, which goes to IDLE
- RDATA, which goes to RDATA_ACK
- RDATA_ACK, which goes to IDLE once the master's acknowledge bit is sampled

Two events override every state. A stop forces IDLE. A start forces ADDR.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, register 0 reads 0x00, register 1 reads 0xF8 and every other register reads 0x00. `sda_oe` is 0 after reset.
- R2: When the first byte after a start carries the slave address in bits [7:1], the slave pulls SDA low during the ninth clock slot. Bit 0 of that byte is 0 for a write and 1 for a read.
- R3: When the address does not match, the slave does not acknowledge, leaves SDA released and ignores the bus until the next start or stop. No register changes.
- R4: A command byte with bit 7 set and bits [6:0] below the register count is acknowledged. The data byte that follows is acknowledged and written to that register.
- R5: A command byte is not acknowledged if bit 7 is clear or if its offset is at or beyond the register count. Such a command changes no register.
- R6: A read uses a repeated start and then the address with the read bit. The slave acknowledges and then drives the selected register MSB first. It releases SDA for the master's acknowledge slot and returns to idle after sampling that slot.
- R7: A read that follows no accepted command in the current transaction returns 0xFF.
- R8: `spread_sel` always equals register 0 bits [7:5], and `freq_sel` always equals register 0 bits [4:0].
- R9: A start or stop that arrives in the middle of a data byte aborts the transfer. No partial write is committed.
- R10: The slave changes its SDA drive only while the synchronized SCL is low.
- R11: A stop returns the slave to idle and discards any accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| spread_sel | output | 3 | Register 0 bits [7:5] |
| freq_sel | output | 5 | Register 0 bits [4:0] |
| cfg_regs | output | NREGS*8 | All registers, register i in bits [8i+7:8i] |

## Verification
The assertions rely on the master keeping both SCL half-periods several system-clock cycles longer than the synchronizer delay. They also rely on the master changing SDA only while SCL is low, except when it forms a start or a stop. The bench master holds each phase for eight clock cycles and changes SDA only with SCL low. Random transactions mix the following:
- matching and mismatching addresses
- commands with bit 7 clear
- out-of-range offsets
- reads and writes

Directed cases add the mid-byte aborts and a read issued after a stop.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK
    } smb_state_e;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // SDA edges while SCL stays high mark bus conditions
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
    parameter int NREGS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [6:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [6:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [NREGS*8-1:0] regs_flat
);

    logic [7:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = (g == 1) ? 8'hF8 : 8'h00;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == 7'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = regs[g];
    end

    // Unimplemented offsets read as all ones
    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_idx == 7'(i)) rd_data = regs[i];
        end
    end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLV_ADDR    = 7'h69,
    parameter int         NREGS       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    output logic [2:0]         spread_sel,
    output logic [4:0]         freq_sel,
    output logic [NREGS*8-1:0] cfg_regs
);

    localparam logic [6:0] NREGS7   = 7'(NREGS);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    smb_state_e state, nstate;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic [6:0] offs;
    logic       cmd_ok;
    logic       is_rd;
    logic       byte_end;
    logic       cmd_good;
    logic       wr_en;
    logic [7:0] rd_data;
    logic [6:0] rd_idx;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    assign byte_end = scl_fall && (bit_cnt == LAST_BIT);
    assign cmd_good = shreg[7] && (shreg[6:0] < NREGS7);
    assign rd_idx   = cmd_ok ? offs : 7'h7F;

    smb_reg_bank #(.NREGS(NREGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (offs),
        .wr_data   (shreg),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .regs_flat (cfg_regs)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        if (stop_evt) begin
            nstate = S_IDLE;
        end else if (start_evt) begin
            nstate = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE:      nstate = S_IDLE;
                S_ADDR:      if (byte_end) nstate = (shreg[7:1] == SLV_ADDR) ? S_ADDR_ACK : S_IDLE;
                S_ADDR_ACK:  if (scl_fall) nstate = is_rd ? S_RDATA : S_CMD;
                S_CMD:       if (byte_end) nstate = cmd_good ? S_CMD_ACK : S_IDLE;
                S_CMD_ACK:   if (scl_fall) nstate = S_WDATA;
                S_WDATA:     if (byte_end) nstate = S_WDATA_ACK;
                S_WDATA_ACK: if (scl_fall) nstate = S_IDLE;
                S_RDATA:     if (byte_end) nstate = S_RDATA_ACK;
                S_RDATA_ACK: if (scl_rise) nstate = S_IDLE;
                default:     nstate = S_IDLE;
            endcase
        end
    end

    // Shift, count and command datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '1;
            offs    <= '0;
            cmd_ok  <= 1'b0;
            is_rd   <= 1'b0;
        end else if (stop_evt) begin
            bit_cnt <= '0;
            cmd_ok  <= 1'b0;
        end else if (start_evt) begin
            bit_cnt <= '0;
        end else begin
            if (scl_rise && (state inside {S_ADDR, S_CMD, S_WDATA, S_RDATA})) begin
                shreg   <= {shreg[6:0], sda_s};
                bit_cnt <= bit_cnt + 4'd1;
            end
            if ((state == S_ADDR) && byte_end) begin
                is_rd <= shreg[0];
            end
            if ((state == S_CMD) && byte_end) begin
                cmd_ok <= cmd_good;
                if (cmd_good) offs <= shreg[6:0];
            end
            if ((state inside {S_ADDR_ACK, S_CMD_ACK}) && scl_fall) begin
                bit_cnt <= '0;
                tx      <= rd_data;
            end
            if ((state == S_RDATA) && scl_fall && !byte_end) begin
                tx <= {tx[6:0], 1'b1};
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            S_ADDR_ACK, S_CMD_ACK, S_WDATA_ACK: sda_oe = 1'b1;
            S_RDATA:                            sda_oe = ~tx[7];
            S_WDATA:                            wr_en  = byte_end && !start_evt && !stop_evt;
            default:                            ;
        endcase
    end

    assign spread_sel = cfg_regs[7:5];
    assign freq_sel   = cfg_regs[4:0];

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
#(
    parameter int NREGS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input smb_state_e         state,
    input logic               sda_oe,
    input logic               scl_s,
    input logic               start_evt,
    input logic               stop_evt,
    input logic               wr_en,
    input logic [NREGS*8-1:0] cfg_regs
);

    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == S_IDLE));

    a_r9_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !stop_evt) |=> (state == S_ADDR));

    a_r3_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_regs));

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);

    a_r4_write_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == S_WDATA));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREGS(NREGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .wr_en     (wr_en),
    .cfg_regs  (cfg_regs)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;

    localparam logic [6:0] ADDR  = 7'h69;
    localparam int         NREGS = 4;
    localparam int         H     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_bus;
    logic sda_oe;
    logic [2:0] spread_sel;
    logic [4:0] freq_sel;
    logic [NREGS*8-1:0] cfg_regs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] model [NREGS];

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smb_cfg_slave #(.SLV_ADDR(ADDR), .NREGS(NREGS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_bus),
        .sda_oe     (sda_oe),
        .spread_sel (spread_sel),
        .freq_sel   (freq_sel),
        .cfg_regs   (cfg_regs)
    );

    function automatic logic [7:0] reset_val(input int i);
        return (i == 1) ? 8'hF8 : 8'h00;
    endfunction

    function automatic bit cmd_accept(input logic [7:0] c);
        return c[7] && (int'(c[6:0]) < NREGS);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wt(H);
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; wt(H);
        m_scl = 1'b1; wt(H/2);
        ack = !sda_bus;
        wt(H/2);
        m_scl = 1'b0;
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            m_scl = 1'b1; wt(H/2);
            b[i] = sda_bus;
            wt(H/2);
            m_scl = 1'b0;
        end
        wt(2);
        m_sda = nack; wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(2);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREGS; i++)
            chk(cfg_regs[i*8 +: 8] == model[i], req, cfg_regs[i*8 +: 8], model[i]);
        chk(spread_sel == model[0][7:5], "R8 spread", spread_sel, model[0][7:5]);
        chk(freq_sel == model[0][4:0], "R8 freq", freq_sel, model[0][4:0]);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d);
        bit aa, ca, da;
        bit exp_a, exp_c;
        exp_a = (a == ADDR);
        exp_c = exp_a && cmd_accept(c);
        bus_start();
        send_byte({a, 1'b0}, aa);
        chk(aa == exp_a, exp_a ? "R2 addr ack" : "R3 addr nack", aa, exp_a);
        send_byte(c, ca);
        chk(ca == exp_c, exp_c ? "R4 cmd ack" : "R5 cmd nack", ca, exp_c);
        send_byte(d, da);
        chk(da == exp_c, "R4 data ack", da, exp_c);
        bus_stop();
        if (exp_c) model[c[6:0]] = d;
        chk(sda_oe == 1'b0, "R11 idle after stop", sda_oe, 0);
        check_regs(exp_c ? "R4 reg write" : "R5 reg unchanged");
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] c);
        bit aa, ca, ra;
        logic [7:0] rb, exp_b;
        bit exp_a, exp_c;
        exp_a = (a == ADDR);
        exp_c = exp_a && cmd_accept(c);
        exp_b = exp_c ? model[c[6:0]] : 8'hFF;
        bus_start();
        send_byte({a, 1'b0}, aa);
        chk(aa == exp_a, "R2 addr ack (rd)", aa, exp_a);
        send_byte(c, ca);
        chk(ca == exp_c, "R5 cmd ack (rd)", ca, exp_c);
        bus_start();
        send_byte({a, 1'b1}, ra);
        chk(ra == exp_a, "R6 read addr ack", ra, exp_a);
        recv_byte(1'b1, rb);
        chk(rb == exp_b, exp_c ? "R6 read data" : "R7 read 0xFF", rb, exp_b);
        chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        bus_stop();
        check_regs("R3 regs after read");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        void'($urandom(32'd2024));
        for (int i = 0; i < NREGS; i++) model[i] = reset_val(i);
        wt(5);
        rst_n = 1'b1;
        wt(5);
        // R1: reset contents
        chk(sda_oe == 1'b0, "R1 sda_oe reset", sda_oe, 0);
        check_regs("R1 reset value");

        // Directed
        do_write(ADDR, 8'h80, 8'hA5);           // R8 fields split 101/00101
        do_read(ADDR, 8'h81);                   // R6 reset value of reg 1
        do_write(ADDR, 8'h01, 8'h3C);           // R5 bit 7 clear
        do_write(ADDR, 8'h80 | 8'(NREGS), 8'h11); // R5 offset out of range
        do_write(7'h12, 8'h82, 8'h77);          // R3 wrong address
        do_read(ADDR, 8'h05);                   // R7 rejected command

        // R11: stop discards the accepted command
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h82, ack);
        chk(ack == 1'b1, "R11 cmd ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        recv_byte(1'b1, rb);
        chk(rb == 8'hFF, "R11 cmd discarded by stop", rb, 8'hFF);
        bus_stop();

        // R9: stop in mid data byte
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h82, ack);
        send_bits(8'hFF, 5);
        bus_stop();
        check_regs("R9 stop abort no write");

        // R9: repeated start in mid data byte, then read back
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h83, ack);
        send_bits(8'h5A, 3);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        recv_byte(1'b1, rb);
        chk(rb == model[3], "R9 start abort no write", rb, model[3]);
        bus_stop();
        check_regs("R9 regs after start abort");

        // Random mix
        for (int n = 0; n < 40; n++) begin
            logic [6:0] a;
            logic [7:0] c;
            logic [7:0] d;
            a = (($urandom % 6) == 0) ? 7'($urandom) : ADDR;
            c = {(($urandom % 5) != 0), 7'($urandom % (NREGS + 2))};
            d = 8'($urandom);
            if ($urandom % 2) do_write(a, c, d);
            else              do_read(a, c);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule